// File: doc/BRIEF.md
# Bit-Selected Reset PWM Timer

This block produces one pulse-width-modulated output from an 8-bit up-counter that steps once for each pulse of a slow tick enable (nominally 32 kHz) applied alongside the system clock. The PWM period is not set by a compare-to-top value. A 2-bit prescaler instead picks which counter bit, once it would become set, sends the counter back to zero. Prescaler p leaves 7 − p bits of active count and gives a period of 128 >> p ticks: 128, 64, 32 or 16 ticks.

A 7-bit duty value is compared with the active low bits of the counter. The output is high while those bits are below the duty value. Software reaches the block through a byte-wide register port with two locations. Location 0 holds the run enable and the prescaler. Location 1 holds the duty value. Every change takes effect at once and is never deferred to a period boundary. A change of prescaler leaves the counter as it is, so the output may glitch at the switch. Driver software is expected to order its writes so that this does not matter.

Top module: `pwm_bitreset_timer`

## Requirements
- R1: After reset the output is low, and both registers read back as 0x00.
- R2: The counter moves only on a clock edge where `tick_en` is high. Without ticks, the output and the counter hold their values.
- R3: With prescaler p, the counter counts 0 .. (128 >> p) − 1 and then returns to 0. In steady state the output is high for exactly `duty` ticks out of every 128 >> p.
- R4: The output is registered. In the cycle after an edge it is high exactly when the enable was set at that edge and the low (7 − p) counter bits were below the duty value.
- R5: A duty value of 128 >> p or more keeps the output high in every cycle. With p = 0 the largest duty, 127, gives 127 high ticks out of 128.
- R6: A duty value of 0 keeps the output low.
- R7: Location 0 bit 7 is the enable. While it is clear, the output is low and the counter is held at zero, so after it is set again a period starts from count 0.
- R8: Writing a new prescaler (location 0, bits 1:0) does not clear the counter. Counting carries on from the current value, using the new active bit range.
- R9: A new duty value (location 1, bits 6:0) takes part in the comparison from the next edge, inside the current period.
- R10: A read strobe returns the addressed register on `reg_rdata` in the cycle after the strobe, and the value holds until the next read. Location 0 reads {enable, 00000, prescaler} and location 1 reads {0, duty}. Bits 6:2 of location 0 and bit 7 of location 1 ignore writes and read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Time-base tick, one clock wide, advances the counter |
| reg_addr | input | 1 | Register select: 0 control, 1 duty |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| pwm_out | output | 1 | PWM output, registered |

## Verification
The output is compared every cycle against a cycle-level model while the bench steps through all four prescalers. Duty values are chosen inside the period, exactly at it, above it, at zero and at 127 with prescaler 0, which separates the period wrap from the compare range. Sparse ticks show that the counter steps only on `tick_en`. A prescaler switch at count 40 shows that the counter keeps its value rather than being cleared. A duty change mid-period and a disable/enable cycle show that updates are immediate and that the disable clears the counter. Register reads after writes of all-ones data show the unused bits masked.

// File: rtl/pwmbr_pkg.sv
package pwmbr_pkg;
  localparam int CNT_W  = 8;
  localparam int PRE_W  = 2;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 1;
  localparam int EN_BIT = 7;
  localparam logic [ADDR_W-1:0] CTRL_OFS = 1'b0;
  localparam logic [ADDR_W-1:0] DUTY_OFS = 1'b1;
endpackage

// File: rtl/pwmbr_rst_sync.sv
module pwmbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pwmbr_regs.sv
module pwmbr_regs
  import pwmbr_pkg::*;
#(
  parameter int DUTY_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic              en_o,
  output logic [PRE_W-1:0]  presc_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              en_q, en_d;
  logic [PRE_W-1:0]  presc_q, presc_d;
  logic [DUTY_W-1:0] duty_q, duty_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              ctrl_we, duty_we;
  logic [DATA_W-1:0] ctrl_view, duty_view;
  logic              unused_wbits;

  assign unused_wbits = ^wdata_i;

  always_comb begin
    ctrl_we = wr_i && (addr_i == CTRL_OFS);
    duty_we = wr_i && (addr_i == DUTY_OFS);
    en_d    = wdata_i[EN_BIT];
    presc_d = wdata_i[PRE_W-1:0];
    duty_d  = wdata_i[DUTY_W-1:0];
  end

  always_comb begin
    ctrl_view                = '0;
    ctrl_view[EN_BIT]        = en_q;
    ctrl_view[PRE_W-1:0]     = presc_q;
    duty_view                = '0;
    duty_view[DUTY_W-1:0]    = duty_q;
    rdata_d = (addr_i == CTRL_OFS) ? ctrl_view : duty_view;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      presc_q <= '0;
    end else if (ctrl_we) begin
      en_q    <= en_d;
      presc_q <= presc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       duty_q <= '0;
    else if (duty_we) duty_q <= duty_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_i)  rdata_q <= rdata_d;
  end

  assign en_o    = en_q;
  assign presc_o = presc_q;
  assign duty_o  = duty_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/pwmbr_counter.sv
module pwmbr_counter #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [PRE_W-1:0] presc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int NUM_SEL = 1 << PRE_W;

  logic [CNT_W-1:0]   cnt_q, cnt_d, cnt_inc;
  logic [NUM_SEL-1:0] wrap_vec;
  logic               cnt_ld;

  assign cnt_inc = cnt_q + 1'b1;

  // One wrap candidate per prescaler setting: the bit that clears the count.
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_wrap
    assign wrap_vec[g] = cnt_inc[CNT_W-1-g];
  end

  always_comb begin
    cnt_ld = !en_i || tick_i;
    if (!en_i)                 cnt_d = '0;
    else if (wrap_vec[presc_i]) cnt_d = '0;
    else                       cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwmbr_duty_cmp.sv
module pwmbr_duty_cmp #(
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 2,
  parameter int DUTY_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [PRE_W-1:0]  presc_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);
  localparam int NUM_SEL = 1 << PRE_W;

  logic [CNT_W-1:0] mask_tbl [NUM_SEL];
  logic [CNT_W-1:0] active;
  logic [CNT_W-1:0] duty_ext;
  logic             pwm_d, pwm_q;

  // Active-bit mask for each prescaler setting.
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_mask
    localparam int SPAN_BITS = CNT_W - 1 - g;
    assign mask_tbl[g] = CNT_W'((1 << SPAN_BITS) - 1);
  end

  always_comb begin
    active   = cnt_i & mask_tbl[presc_i];
    duty_ext = CNT_W'(duty_i);
    pwm_d    = en_i && (active < duty_ext);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/pwm_bitreset_timer.sv
module pwm_bitreset_timer
  import pwmbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pwm_out
);
  localparam int DUTY_W = CNT_W - 1;

  logic              rst_int_n;
  logic              ctrl_en;
  logic [PRE_W-1:0]  ctrl_presc;
  logic [DUTY_W-1:0] duty_val;
  logic [CNT_W-1:0]  cnt_val;

  pwmbr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pwmbr_regs #(.DUTY_W(DUTY_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .wr_i    (reg_wr),
    .rd_i    (reg_rd),
    .en_o    (ctrl_en),
    .presc_o (ctrl_presc),
    .duty_o  (duty_val),
    .rdata_o (reg_rdata)
  );

  pwmbr_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en_i    (ctrl_en),
    .tick_i  (tick_en),
    .presc_i (ctrl_presc),
    .cnt_o   (cnt_val)
  );

  pwmbr_duty_cmp #(.CNT_W(CNT_W), .PRE_W(PRE_W), .DUTY_W(DUTY_W)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en_i    (ctrl_en),
    .presc_i (ctrl_presc),
    .cnt_i   (cnt_val),
    .duty_i  (duty_val),
    .pwm_o   (pwm_out)
  );
endmodule

// File: rtl/pwmbr_checker.sv
module pwmbr_checker #(
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 2,
  parameter int DUTY_W = 7,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              reg_rd,
  input logic              en,
  input logic [PRE_W-1:0]  presc,
  input logic [DUTY_W-1:0] duty,
  input logic [CNT_W-1:0]  cnt,
  input logic              pwm_out,
  input logic [DATA_W-1:0] reg_rdata
);
  logic [CNT_W-1:0] span;
  logic             duty_full;

  always_comb begin
    span = '0;
    span[CNT_W-1-presc] = 1'b1;
    duty_full = CNT_W'(duty) >= span;
  end

  // R7: disabled means low output and a cleared counter next cycle
  p_off_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pwm_out && cnt == '0));

  // R2: no tick, no count movement
  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick_en) |=> $stable(cnt));

  // R5: duty at or above the period keeps the output high
  p_full_duty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && duty_full) |=> pwm_out);

  // R6: zero duty keeps the output low
  p_zero_duty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |=> !pwm_out);

  // R10: read data holds without a read strobe
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

bind pwm_bitreset_timer pwmbr_checker #(
  .CNT_W(pwmbr_pkg::CNT_W), .PRE_W(pwmbr_pkg::PRE_W),
  .DUTY_W(pwmbr_pkg::CNT_W-1), .DATA_W(pwmbr_pkg::DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .reg_rd    (reg_rd),
  .en        (ctrl_en),
  .presc     (ctrl_presc),
  .duty      (duty_val),
  .cnt       (cnt_val),
  .pwm_out   (pwm_out),
  .reg_rdata (reg_rdata)
);

// File: tb/pwm_bitreset_timer_tb.sv
module pwm_bitreset_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [0:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       pwm_out;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  // scoreboard queues
  logic pwm_exp_q[$];
  logic [7:0] rd_exp_q[$];

  // model state
  logic       m_en;
  logic [1:0] m_p;
  logic [6:0] m_duty;
  logic [7:0] m_cnt;

  always #5 clk = ~clk;

  pwm_bitreset_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  // Reference model from the requirements; pushes expected items per edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 1'b0; m_p = '0; m_duty = '0; m_cnt = '0;
    end else begin
      logic [7:0] mask, nxt;
      mask = (8'd1 << (7 - m_p)) - 8'd1;
      pwm_exp_q.push_back(m_en && ((m_cnt & mask) < {1'b0, m_duty}));
      if (!m_en) m_cnt = '0;
      else if (tick_en) begin
        nxt = m_cnt + 8'd1;
        m_cnt = nxt[7 - m_p] ? 8'd0 : nxt;
      end
      if (reg_rd)
        rd_exp_q.push_back(reg_addr[0] ? {1'b0, m_duty} : {m_en, 5'b0, m_p});
      if (reg_wr) begin
        if (reg_addr[0]) m_duty = reg_wdata[6:0];
        else begin m_en = reg_wdata[7]; m_p = reg_wdata[1:0]; end
      end
    end
  end

  // Monitor: pops expected items and compares away from the active edge.
  always @(negedge clk) begin
    if (pwm_exp_q.size() > 0) begin
      logic e;
      e = pwm_exp_q.pop_front();
      checks++;
      if (pwm_out !== e) begin
        errors++;
        $display("FAIL %s pwm_out got %b exp %b at %0t", cur_req, pwm_out, e, $time);
      end
    end
    if (rd_exp_q.size() > 0) begin
      logic [7:0] r;
      r = rd_exp_q.pop_front();
      checks++;
      if (reg_rdata !== r) begin
        errors++;
        $display("FAIL R10 reg_rdata got %02h exp %02h", reg_rdata, r);
      end
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      #1 if (pwm_out) h++;
    end
  endtask

  // set prescaler and duty, warm up, then count highs over one period
  task automatic period_check(input string req, input int p, input int d, input int exp_h);
    int h;
    int per;
    per = 128 >> p;
    cur_req = req;
    wr_reg(1'b1, 8'(d));
    wr_reg(1'b0, 8'h80 | 8'(p));
    idle(per + 2);
    count_high(per, h);
    chk(req, h, exp_h);
  endtask

  initial begin
    logic [7:0] rv;
    int h;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R1: reset state
    chk("R1", int'(pwm_out), 0);
    rd_reg(1'b0, rv); chk("R1", int'(rv), 0);
    rd_reg(1'b1, rv); chk("R1", int'(rv), 0);

    // R10: masked fields, read latency via rd_reg
    cur_req = "R10";
    wr_reg(1'b0, 8'h7E);
    rd_reg(1'b0, rv); chk("R10", int'(rv), 8'h02);
    wr_reg(1'b1, 8'hFF);
    rd_reg(1'b1, rv); chk("R10", int'(rv), 8'h7F);
    wr_reg(1'b1, 8'h00);

    tick_en = 1'b1;
    period_check("R3", 2, 10, 10);
    period_check("R4", 0, 100, 100);
    period_check("R3", 3, 5, 5);
    period_check("R4", 1, 33, 33);
    period_check("R5", 1, 64, 64);
    period_check("R5", 3, 100, 16);
    period_check("R5", 0, 127, 127);
    period_check("R6", 2, 0, 0);
    rd_reg(1'b0, rv); chk("R10", int'(rv), 8'h82);

    // R2: sparse ticks, every third cycle
    cur_req = "R2";
    wr_reg(1'b1, 8'd4);
    wr_reg(1'b0, 8'h83);
    repeat (60) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
      @(negedge clk);
    end
    tick_en = 1'b0;
    idle(10);
    chk("R2", int'(pwm_out), 0 );

    // R7: disable holds output low, re-enable restarts from count 0
    cur_req = "R7";
    tick_en = 1'b1;
    wr_reg(1'b0, 8'h03);
    count_high(20, h); chk("R7", h, 0);
    wr_reg(1'b0, 8'h83);
    count_high(3, h); chk("R7", h, 3);

    // R8: prescaler switch mid-count, per-cycle scoreboard compares
    cur_req = "R8";
    wr_reg(1'b1, 8'd4);
    wr_reg(1'b0, 8'h00);
    wr_reg(1'b0, 8'h80);
    idle(38);
    wr_reg(1'b0, 8'h83);
    idle(40);

    // R9: duty changed inside a period
    cur_req = "R9";
    wr_reg(1'b0, 8'h80);
    idle(20);
    wr_reg(1'b1, 8'd90);
    idle(10);
    wr_reg(1'b1, 8'd3);
    idle(140);

    tick_en = 1'b0;
    idle(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule